// File: doc/BRIEF.md
# Quad-Channel DAC Serial Load Front End

This block is the digital front end of a four-channel digital-to-analog converter. A host sends 24-bit frames, most significant bit first, over a three-wire serial link: the frame advances one bit on every rising edge of the logical OR of a select line and a serial clock, so either wire can act as the shift clock. Each frame carries a channel address, a broadcast flag and a 16-bit code. While a level-sensitive latch strobe is held low, the code in the shift register flows into the staging register of the addressed channel, or into all four staging registers when the broadcast flag is set.

A rising edge on a separate commit pin copies all four staging registers into the four output (converter) registers in the same cycle. A host can therefore stage new codes channel by channel without disturbing the outputs, then change every output at once. A rising edge on a clear pin forces all output registers to zero or to midscale, selected by a level pin, and leaves the serial shift register alone.

Every pin is brought into the system clock domain through a two-flop synchronizer, and edges are found on the synchronized copies. The system clock must run at least four times faster than the serial clock. The block outputs the four 16-bit output register values. The analog conversion that follows is out of scope.

Top module: `quad_dac_front`

## Requirements
- R1: Frame layout, sent most significant bit first: bits 23:22 hold the channel address (0 = A, 1 = B, 2 = C, 3 = D), bit 21 is the broadcast flag, bits 15:0 are the code, and bits 20:16 have no effect. Channel c appears on `dac_codes_o[16c+15:16c]`.
- R2: The shift register advances by one bit on each rising edge of (sel_n_i OR sclk_i), capturing sdin_i. Driving the edges on sel_n_i with sclk_i held low gives the same result as driving them on sclk_i with sel_n_i held low.
- R3: If sel_n_i rises while sclk_i is low, that rising edge of the OR shifts in one extra bit.
- R4: With no rising edge of the OR, the shift register holds its value whatever sdin_i does, and a rising edge on clr_trig_i leaves it unchanged.
- R5: While latch_n_i is low, the addressed staging register follows the shift register continuously, so bits shifted in with latch_n_i low write every channel that the moving address and flag select along the way.
- R6: When the broadcast flag is 1, latch_n_i low writes the code into all four staging registers, whatever the address bits are.
- R7: While latch_n_i is high, the staging registers hold their values.
- R8: A low-to-high edge of commit_i copies all four staging registers into the output registers in one cycle. A steady high or low level causes no update.
- R9: A rising edge of clr_trig_i sets all four output registers to 0x0000 when clr_mid_i is low and to 0x8000 when clr_mid_i is high.
- R10: When a commit edge and a clear edge are detected in the same cycle, the clear wins.
- R11: The synchronous system reset (rst_n low) clears the shift register and the staging registers and sets the output registers to 0x8000 if clr_mid_i is high, else 0x0000. Pins held high through reset produce no edge when it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous system reset, active low |
| sel_n_i | input | 1 | Serial select; ORed with sclk_i to form the shift clock |
| sclk_i | input | 1 | Serial clock; ORed with sel_n_i to form the shift clock |
| sdin_i | input | 1 | Serial data, most significant bit first |
| latch_n_i | input | 1 | Level strobe, low writes shift register into staging registers |
| commit_i | input | 1 | Rising edge copies staging registers to output registers |
| clr_trig_i | input | 1 | Rising edge clears output registers |
| clr_mid_i | input | 1 | Clear value select: 0 gives 0x0000, 1 gives 0x8000 |
| dac_codes_o | output | 64 | Four 16-bit output register values, channel A in the low bits |

## Verification
The loading path is driven with frames that address each channel, frames that broadcast from two different addresses, and frames with the unused bits set, so wrong address decoding, an ignored broadcast flag or a stray field bit each show up on a different channel. Frames are shifted once with the serial clock and once with the select line, which separates a shift clock taken from only one pin from the true OR. A frame closed with the serial clock low must land one bit further along, and a frame shifted with the latch strobe held low must leave intermediate codes in the channels its passing address touched. Commit and clear are tried as held levels, as isolated edges and as edges arriving together.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Pin bundle carried through the synchronizer, in a fixed order.
    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic sdin;
        logic latch_n;
        logic commit;
        logic clr_trig;
        logic clr_mid;
    } pins_t;

    localparam int PIN_COUNT = $bits(pins_t);

    // Value of each synchronizer stage in reset: strobe pins idle high so
    // that a pin held high through reset gives no edge on release.
    localparam pins_t PINS_IDLE = '{
        sel_n:    1'b1,
        sclk:     1'b1,
        sdin:     1'b0,
        latch_n:  1'b1,
        commit:   1'b1,
        clr_trig: 1'b1,
        clr_mid:  1'b0
    };

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.s1 <= RST_VAL;
            q.s2 <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.s2;

endmodule

// File: rtl/qdac_edge.sv
module qdac_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_s,
    input  logic sclk_s,
    input  logic commit_s,
    input  logic clr_trig_s,
    output logic shift_ev,
    output logic commit_ev,
    output logic clear_ev
);

    typedef struct packed {
        logic prev_or;
        logic prev_commit;
        logic prev_clr;
    } st_t;

    st_t  q, d;
    logic shift_clk;

    // The shift clock is the OR of the two serial pins.
    assign shift_clk = sel_n_s | sclk_s;

    always_comb begin
        d             = q;
        d.prev_or     = shift_clk;
        d.prev_commit = commit_s;
        d.prev_clr    = clr_trig_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.prev_or     <= 1'b1;
            q.prev_commit <= 1'b1;
            q.prev_clr    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign shift_ev  = shift_clk  & ~q.prev_or;
    assign commit_ev = commit_s   & ~q.prev_commit;
    assign clear_ev  = clr_trig_s & ~q.prev_clr;

    // A rise needs a low level in between, so two in a row cannot occur.
    AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ev |=> !shift_ev);                                   // R2
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ev |=> !commit_ev);                                 // R8

endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
    parameter int FRAME_W = 24,
    parameter int CODE_W  = 16,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_ev,
    input  logic              sdin_s,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bcast_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int BCAST_BIT = FRAME_W - ADDR_W - 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (shift_ev) begin
            d.sr = {q.sr[FRAME_W-2:0], sdin_s};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sr <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_o  = q.sr[FRAME_W-1 -: ADDR_W];
    assign bcast_o = q.sr[BCAST_BIT];
    assign code_o  = q.sr[CODE_W-1:0];

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_ev |=> $stable(q.sr));                              // R4
    AST_SR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ev |=> (q.sr[0] == $past(sdin_s)) &&
                     (q.sr[FRAME_W-1:1] == $past(q.sr[FRAME_W-2:0]))); // R2

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
    parameter int NCH    = 4,
    parameter int CODE_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rst_mid,
    input  logic                         latch_n_s,
    input  logic                         clr_mid_s,
    input  logic                         commit_ev,
    input  logic                         clear_ev,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         bcast,
    input  logic [CODE_W-1:0]            code,
    output logic [NCH-1:0][CODE_W-1:0]   dac_o
);

    localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] stage;
        logic [NCH-1:0][CODE_W-1:0] dac;
    } st_t;

    st_t  q, d;
    logic latch_act;

    assign latch_act = ~latch_n_s;

    always_comb begin
        d = q;
        // Staging registers: level-sensitive path from the shift register.
        if (latch_act) begin
            for (int c = 0; c < NCH; c++) begin
                if (bcast || (addr == ADDR_W'(c))) begin
                    d.stage[c] = code;
                end
            end
        end
        // Output registers: clear edge has priority over commit edge.
        if (clear_ev) begin
            for (int c = 0; c < NCH; c++) begin
                d.dac[c] = clr_mid_s ? MID : ZERO;
            end
        end else if (commit_ev) begin
            d.dac = q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.stage <= '0;
            for (int c = 0; c < NCH; c++) begin
                q.dac[c] <= rst_mid ? MID : ZERO;
            end
        end else begin
            q <= d;
        end
    end

    assign dac_o = q.dac;

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_act |=> $stable(q.stage));                          // R7
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_ev && !clear_ev) |=> $stable(q.dac));             // R8
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ev && !clear_ev) |=> (q.dac == $past(q.stage)));   // R8

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            clear_ev |=> (q.dac[g] == ($past(clr_mid_s) ? MID : ZERO))); // R9 R10
        AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_act && bcast) |=> (q.stage[g] == $past(code)));  // R6
    end

endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front #(
    parameter int NCH     = 4,
    parameter int CODE_W  = 16,
    parameter int FRAME_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n_i,
    input  logic                    sclk_i,
    input  logic                    sdin_i,
    input  logic                    latch_n_i,
    input  logic                    commit_i,
    input  logic                    clr_trig_i,
    input  logic                    clr_mid_i,
    output logic [NCH*CODE_W-1:0]   dac_codes_o
);

    import qdac_pkg::*;

    localparam int ADDR_W = $clog2(NCH);

    pins_t pins_raw, pins_s;

    logic              shift_ev, commit_ev, clear_ev;
    logic [ADDR_W-1:0] addr;
    logic              bcast;
    logic [CODE_W-1:0] code;
    logic [NCH-1:0][CODE_W-1:0] dac;

    always_comb begin
        pins_raw.sel_n    = sel_n_i;
        pins_raw.sclk     = sclk_i;
        pins_raw.sdin     = sdin_i;
        pins_raw.latch_n  = latch_n_i;
        pins_raw.commit   = commit_i;
        pins_raw.clr_trig = clr_trig_i;
        pins_raw.clr_mid  = clr_mid_i;
    end

    qdac_sync #(
        .W       (PIN_COUNT),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    qdac_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_s    (pins_s.sel_n),
        .sclk_s     (pins_s.sclk),
        .commit_s   (pins_s.commit),
        .clr_trig_s (pins_s.clr_trig),
        .shift_ev   (shift_ev),
        .commit_ev  (commit_ev),
        .clear_ev   (clear_ev)
    );

    qdac_shift #(
        .FRAME_W (FRAME_W),
        .CODE_W  (CODE_W),
        .ADDR_W  (ADDR_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_ev (shift_ev),
        .sdin_s   (pins_s.sdin),
        .addr_o   (addr),
        .bcast_o  (bcast),
        .code_o   (code)
    );

    qdac_bank #(
        .NCH    (NCH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_mid   (clr_mid_i),
        .latch_n_s (pins_s.latch_n),
        .clr_mid_s (pins_s.clr_mid),
        .commit_ev (commit_ev),
        .clear_ev  (clear_ev),
        .addr      (addr),
        .bcast     (bcast),
        .code      (code),
        .dac_o     (dac)
    );

    assign dac_codes_o = dac;

    AST_EVENTS_NEED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_ev |=> !clear_ev);                                   // R9

endmodule

// File: tb/quad_dac_front_test.sv
module quad_dac_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n_i = 1'b1;
    logic        sclk_i = 1'b1;
    logic        sdin_i = 1'b0;
    logic        latch_n_i = 1'b1;
    logic        commit_i = 1'b0;
    logic        clr_trig_i = 1'b0;
    logic        clr_mid_i = 1'b0;
    logic [63:0] dac_codes_o;

    int checks = 0;
    int fails  = 0;

    // Bench model built from the requirements.
    logic [23:0] sr_m = '0;
    logic [15:0] stage_m [4];
    logic [15:0] dac_m   [4];

    // Table: {channel mask, frame}. R1 R6
    localparam logic [27:0] VEC [8] = '{
        {4'b0001, 24'h00_1234},
        {4'b0010, 24'h40_ABCD},
        {4'b0100, 24'h80_00FF},
        {4'b1000, 24'hC0_FFFF},
        {4'b1111, 24'h20_7777},
        {4'b1111, 24'hE0_0001},
        {4'b0010, 24'h5F_4242},
        {4'b0100, 24'h9F_9999}
    };

    always #4 clk = ~clk;   // 125 MHz

    quad_dac_front uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_i     (sel_n_i),
        .sclk_i      (sclk_i),
        .sdin_i      (sdin_i),
        .latch_n_i   (latch_n_i),
        .commit_i    (commit_i),
        .clr_trig_i  (clr_trig_i),
        .clr_mid_i   (clr_mid_i),
        .dac_codes_o (dac_codes_o)
    );

    task automatic pin_wait();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_dac(input string tag);
        logic [63:0] exp;
        exp = {dac_m[3], dac_m[2], dac_m[1], dac_m[0]};
        checks++;
        if (dac_codes_o !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, dac_codes_o, exp);
        end
    endtask

    task automatic apply_latch();
        for (int c = 0; c < 4; c++) begin
            if (sr_m[21] || (sr_m[23:22] == 2'(c))) stage_m[c] = sr_m[15:0];
        end
    endtask

    task automatic model_shift(input logic b);
        sr_m = {sr_m[22:0], b};
        if (!latch_n_i) apply_latch();
    endtask

    task automatic clk_bit(input logic b);
        sclk_i = 1'b0; sdin_i = b; pin_wait();
        sclk_i = 1'b1; pin_wait();
        model_shift(b);
    endtask

    task automatic sel_bit(input logic b);
        sel_n_i = 1'b0; sdin_i = b; pin_wait();
        sel_n_i = 1'b1; pin_wait();
        model_shift(b);
    endtask

    task automatic send_word(input logic [23:0] w);
        sel_n_i = 1'b0; pin_wait();
        for (int i = 23; i >= 0; i--) clk_bit(w[i]);
        sel_n_i = 1'b1; pin_wait();
    endtask

    task automatic latch_pulse();
        latch_n_i = 1'b0; pin_wait();
        apply_latch();
        latch_n_i = 1'b1; pin_wait();
    endtask

    task automatic commit_pulse();
        commit_i = 1'b1; pin_wait();
        for (int c = 0; c < 4; c++) dac_m[c] = stage_m[c];
        commit_i = 1'b0; pin_wait();
    endtask

    task automatic clear_pulse();
        clr_trig_i = 1'b1; pin_wait();
        for (int c = 0; c < 4; c++) dac_m[c] = clr_mid_i ? 16'h8000 : 16'h0000;
        clr_trig_i = 1'b0; pin_wait();
    endtask

    task automatic model_reset();
        sr_m = '0;
        for (int c = 0; c < 4; c++) begin
            stage_m[c] = '0;
            dac_m[c]   = clr_mid_i ? 16'h8000 : 16'h0000;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset with clear select low
        model_reset();
        repeat (3) @(negedge clk);
        check_dac("R11 reset zero");
        rst_n = 1'b1;
        pin_wait();
        check_dac("R11 after release");

        // Table walk: addressing, broadcast, ignored bits. R1 R6
        foreach (VEC[i]) begin
            send_word(VEC[i][23:0]);
            latch_n_i = 1'b0; pin_wait();
            for (int c = 0; c < 4; c++)
                if (VEC[i][24 + c]) stage_m[c] = VEC[i][15:0];
            latch_n_i = 1'b1; pin_wait();
            commit_pulse();
            check_dac($sformatf("R1 R6 vector %0d", i));
        end

        // R2: shifting with select edges, serial clock held low
        sclk_i = 1'b0; pin_wait();
        for (int i = 23; i >= 0; i--) sel_bit(logic'(24'hC0_5A5A >> i));
        sclk_i = 1'b1; pin_wait();
        latch_pulse(); commit_pulse();
        check_dac("R2 select as shift clock");

        // R3: select rises while serial clock low -> extra bit
        sel_n_i = 1'b0; pin_wait();
        for (int i = 23; i >= 0; i--) clk_bit(logic'(24'h41_1111 >> i));
        sclk_i = 1'b0; sdin_i = 1'b1; pin_wait();
        sel_n_i = 1'b1; pin_wait();
        model_shift(1'b1);
        sclk_i = 1'b1; pin_wait();
        latch_pulse(); commit_pulse();
        check_dac("R3 extra shift lands on channel C");

        // R9 zero, and R4 clear edge mid-frame leaves shift register alone
        clr_mid_i = 1'b0; pin_wait();
        sel_n_i = 1'b0; pin_wait();
        for (int i = 23; i >= 12; i--) clk_bit(logic'(24'h80_3C3C >> i));
        clear_pulse();
        check_dac("R9 clear to zero");
        for (int i = 11; i >= 0; i--) clk_bit(logic'(24'h80_3C3C >> i));
        sel_n_i = 1'b1; pin_wait();
        latch_pulse(); commit_pulse();
        check_dac("R4 frame intact across clear");

        // R4: data toggling without shift edges changes nothing
        for (int i = 0; i < 6; i++) begin sdin_i = ~sdin_i; pin_wait(); end
        stage_m[2] = 16'hDEAD;  // poison model then relatch from true sr
        latch_pulse(); commit_pulse();
        check_dac("R4 shift register held");

        // R9 midscale
        clr_mid_i = 1'b1; pin_wait();
        clear_pulse();
        check_dac("R9 clear to midscale");

        // R7: frame shifted with latch high leaves staging untouched
        send_word(24'h00_AAAA);
        commit_pulse();
        check_dac("R7 staging held while latch high");

        // R5: latch held low during shifting; passing addresses written
        latch_n_i = 1'b0; pin_wait();
        apply_latch();
        send_word(24'h9F_0F0F);
        latch_n_i = 1'b1; pin_wait();
        commit_pulse();
        check_dac("R5 flow-through while latch low");

        // R8: held high level does not update
        commit_i = 1'b1; pin_wait();
        for (int c = 0; c < 4; c++) dac_m[c] = stage_m[c];
        send_word(24'h40_1357);
        latch_pulse();
        check_dac("R8 steady high no update");
        commit_i = 1'b0; pin_wait();
        check_dac("R8 falling edge no update");
        commit_pulse();
        check_dac("R8 rising edge updates");

        // R10: clear and commit edges in the same cycle
        send_word(24'h20_2468);
        latch_pulse();
        clr_mid_i = 1'b0; pin_wait();
        commit_i = 1'b1; clr_trig_i = 1'b1; pin_wait();
        for (int c = 0; c < 4; c++) dac_m[c] = 16'h0000;
        commit_i = 1'b0; clr_trig_i = 1'b0; pin_wait();
        check_dac("R10 clear beats commit");

        // R11: reset with midscale select, pins held high through reset
        clr_mid_i = 1'b1; sdin_i = 1'b1; commit_i = 1'b1; clr_trig_i = 1'b1;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_dac("R11 reset midscale");
        rst_n = 1'b1;
        pin_wait();
        check_dac("R11 no edge after release");
        commit_i = 1'b0; clr_trig_i = 1'b0; pin_wait();
        latch_pulse(); commit_pulse();
        check_dac("R11 shift and staging cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule